// File: doc/BRIEF.md
# ADC Conversion Trigger Arbiter with Scan Preemption

This block decides which request owns a single analog-to-digital converter. A software start strobe and an automatic scan request compete for it. The scan request comes from either the PWM period event or a PWM duty event. Scan requests win every contest. A scan request that arrives while a software-started conversion is running aborts that conversion. The block then raises a sticky flag, and the result of the aborted conversion stays marked invalid. Software clears the flag with a one-cycle clear pulse.

The block also produces the converter clock enable from a free-running prescaler. The prescaler divides the system clock by a power of two chosen by a 3-bit code. A conversion lasts a fixed number of converter clock ticks. A one-cycle done pulse follows every conversion that runs to completion. An aborted conversion gives no done pulse and is never restarted by the block.

Top module: `adc_trig_arb`

## Requirements
- R1: If a scan request and a software start arrive in the same cycle while the converter is idle, the scan conversion starts. The software start is dropped and is not queued.
- R2: A scan request that arrives while a software conversion is running ends it. On the next edge `busy_sw` falls and `busy_scan` rises, with no `conv_done` for the software conversion.
- R3: A preemption sets `sw_aborted`. The flag stays set until a cycle with `abort_clr` high and no new preemption, because a preemption in that same cycle wins over the clear.
- R4: `sw_result_valid` goes to 0 when a software conversion starts or is aborted. It goes to 1 when a software conversion completes.
- R5: While `scan_en` is 0, PWM events start nothing.
- R6: `scan_src_sel` = 0 lets only `pwm_period_evt` request a scan. `scan_src_sel` = 1 lets only `pwm_duty_evt` request a scan.
- R7: For `clk_div_sel` = k with k from 0 to 6, `conv_clk_en` is high in exactly one cycle of every 2^k. It is high when the low k bits of a cycle counter are all ones. The counter starts at 0 on the first cycle after reset release and wraps at 64.
- R8: `clk_div_sel` = 7 holds `conv_clk_en` at 0, and a running conversion does not advance.
- R9: A conversion ends on its CONV_TICKS-th converter clock tick. At that edge the busy output clears, and `conv_done` is high for exactly that one following cycle.
- R10: A software start is ignored while any conversion runs. A scan request is ignored while a scan conversion runs.
- R11: After reset every output except `conv_clk_en` is 0. With code 0 `conv_clk_en` is 1, and with any other code it is 0 until the prescaler counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_start | input | 1 | Software conversion start strobe |
| pwm_period_evt | input | 1 | PWM period event pulse |
| pwm_duty_evt | input | 1 | PWM duty event pulse |
| scan_en | input | 1 | Enables scan conversions |
| scan_src_sel | input | 1 | Scan trigger source: 0 = period event, 1 = duty event |
| clk_div_sel | input | 3 | Converter clock divide code: 2^code for codes 0 to 6, 7 = clock stopped |
| abort_clr | input | 1 | Clears the aborted flag |
| conv_clk_en | output | 1 | Converter clock enable |
| busy_sw | output | 1 | A software conversion is running |
| busy_scan | output | 1 | A scan conversion is running |
| conv_done | output | 1 | One-cycle pulse after a completed conversion |
| sw_aborted | output | 1 | Sticky flag: a software conversion was preempted |
| sw_result_valid | output | 1 | The last software conversion completed |

## Verification
The bench builds the block with CONV_TICKS = 3. Conversions are then short enough that one run reaches every divide code and many start, complete and preempt events. At divide-by-1 a preemption can land on a conversion's last tick, where abort and completion fall on the same edge. A long stretch of mixed random stimulus covers that case and also sets and clears the aborted flag in the same cycle.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_SW   = 2'd1,
    OWN_SCAN = 2'd2
  } owner_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler #(
  parameter int DIV_CODES = 7,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             clk_en
);
  localparam int CNT_W = DIV_CODES - 1;

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [DIV_CODES-1:0] en_vec;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  genvar k;
  generate
    for (k = 0; k < DIV_CODES; k++) begin : g_code
      if (k == 0) begin : g_full
        assign en_vec[k] = 1'b1;
      end else begin : g_div
        assign en_vec[k] = &cnt_q[k-1:0];
      end
    end
  endgenerate

  always_comb begin
    clk_en = 1'b0;
    if (int'(div_sel) < DIV_CODES) clk_en = en_vec[div_sel];
  end
endmodule

// File: rtl/adc_conv_sched.sv
module adc_conv_sched
  import adc_arb_pkg::*;
#(
  parameter int CONV_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sw_req,
  input  logic scan_req,
  input  logic abort_clr,
  output logic busy_sw,
  output logic busy_scan,
  output logic done,
  output logic aborted,
  output logic result_valid
);
  localparam int TICK_W = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(CONV_TICKS - 1);

  owner_e            own_q, own_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              abort_q, abort_d;
  logic              valid_q, valid_d;
  logic              preempt;

  always_comb begin
    own_d   = own_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    valid_d = valid_q;
    preempt = 1'b0;
    if (scan_req && own_q != OWN_SCAN) begin
      preempt = (own_q == OWN_SW);
      if (preempt) valid_d = 1'b0;
      own_d = OWN_SCAN;
      cnt_d = '0;
    end else if (sw_req && own_q == OWN_IDLE) begin
      own_d   = OWN_SW;
      cnt_d   = '0;
      valid_d = 1'b0;
    end else if (own_q != OWN_IDLE && tick) begin
      if (cnt_q == LAST_TICK) begin
        done_d = 1'b1;
        if (own_q == OWN_SW) valid_d = 1'b1;
        own_d = OWN_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (preempt)        abort_d = 1'b1;
    else if (abort_clr) abort_d = 1'b0;
    else                abort_d = abort_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= OWN_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      own_q   <= own_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      abort_q <= abort_d;
      valid_q <= valid_d;
    end
  end

  assign busy_sw      = (own_q == OWN_SW);
  assign busy_scan    = (own_q == OWN_SCAN);
  assign done         = done_q;
  assign aborted      = abort_q;
  assign result_valid = valid_q;
endmodule

// File: rtl/adc_trig_arb.sv
module adc_trig_arb #(
  parameter int CONV_TICKS = 4,
  parameter int DIV_CODES  = 7,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             pwm_period_evt,
  input  logic             pwm_duty_evt,
  input  logic             scan_en,
  input  logic             scan_src_sel,
  input  logic [SEL_W-1:0] clk_div_sel,
  input  logic             abort_clr,
  output logic             conv_clk_en,
  output logic             busy_sw,
  output logic             busy_scan,
  output logic             conv_done,
  output logic             sw_aborted,
  output logic             sw_result_valid
);
  logic rst_n_i;
  logic scan_req;

  adc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  adc_clk_prescaler #(
    .DIV_CODES (DIV_CODES),
    .SEL_W     (SEL_W)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .div_sel (clk_div_sel),
    .clk_en  (conv_clk_en)
  );

  always_comb scan_req = scan_en & (scan_src_sel ? pwm_duty_evt : pwm_period_evt);

  adc_conv_sched #(
    .CONV_TICKS (CONV_TICKS)
  ) u_sched (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .tick         (conv_clk_en),
    .sw_req       (sw_start),
    .scan_req     (scan_req),
    .abort_clr    (abort_clr),
    .busy_sw      (busy_sw),
    .busy_scan    (busy_scan),
    .done         (conv_done),
    .aborted      (sw_aborted),
    .result_valid (sw_result_valid)
  );
endmodule

// File: rtl/adc_trig_arb_chk.sv
module adc_trig_arb_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_start,
  input logic             pwm_period_evt,
  input logic             pwm_duty_evt,
  input logic             scan_en,
  input logic             scan_src_sel,
  input logic [SEL_W-1:0] clk_div_sel,
  input logic             abort_clr,
  input logic             conv_clk_en,
  input logic             busy_sw,
  input logic             busy_scan,
  input logic             conv_done,
  input logic             sw_aborted,
  input logic             sw_result_valid
);
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_sw && busy_scan)); // R1

  AST_PREEMPT_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    busy_sw && scan_en && (scan_src_sel ? pwm_duty_evt : pwm_period_evt) |=> busy_scan && !conv_done); // R2

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_aborted && !abort_clr |=> sw_aborted); // R3

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_aborted) |-> $past(busy_sw) && busy_scan); // R3

  AST_ABORT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_aborted) |-> !sw_result_valid); // R4

  AST_SCAN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_scan) |-> $past(scan_en)); // R5

  AST_CLK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    clk_div_sel == 3'd7 |-> !conv_clk_en); // R8

  AST_DIV2_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    clk_div_sel == 3'd1 && $past(clk_div_sel) == 3'd1 && $past(conv_clk_en) |-> !conv_clk_en); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !busy_sw && !busy_scan); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done); // R9
endmodule

bind adc_trig_arb adc_trig_arb_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/adc_trig_arb_tb.sv
module adc_trig_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_TICKS    = 3;
  localparam int WATCHDOG   = 60000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_start, pwm_period_evt, pwm_duty_evt, scan_en, scan_src_sel, abort_clr;
  logic [2:0] clk_div_sel;
  logic       conv_clk_en, busy_sw, busy_scan, conv_done, sw_aborted, sw_result_valid;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles   = 0;
  string cur_req  = "R11";

  // behavioural reference state
  int m_pc, m_own, m_cnt;
  bit m_done, m_abort, m_valid;

  adc_trig_arb #(.CONV_TICKS(N_TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start),
    .pwm_period_evt(pwm_period_evt), .pwm_duty_evt(pwm_duty_evt),
    .scan_en(scan_en), .scan_src_sel(scan_src_sel), .clk_div_sel(clk_div_sel),
    .abort_clr(abort_clr), .conv_clk_en(conv_clk_en), .busy_sw(busy_sw),
    .busy_scan(busy_scan), .conv_done(conv_done), .sw_aborted(sw_aborted),
    .sw_result_valid(sw_result_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  function automatic bit m_clk_en(int pc, int sel);
    if (sel > 6) return 1'b0;
    return ((pc & ((1 << sel) - 1)) == ((1 << sel) - 1));
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    check((int'(clk_div_sel) == 7) ? "R8" : "R7", "conv_clk_en", conv_clk_en,
          m_clk_en(m_pc, int'(clk_div_sel)));
    check(cur_req, "busy_sw",         busy_sw,         m_own == 1);
    check(cur_req, "busy_scan",       busy_scan,       m_own == 2);
    check(cur_req, "conv_done",       conv_done,       m_done);
    check(cur_req, "sw_aborted",      sw_aborted,      m_abort);
    check(cur_req, "sw_result_valid", sw_result_valid, m_valid);
  endtask

  // one clock: model steps at the edge, comparison at the falling edge
  task automatic cyc();
    bit tick, trig, set_ab;
    @(posedge clk);
    tick   = m_clk_en(m_pc, int'(clk_div_sel));
    m_pc   = (m_pc + 1) % 64;
    trig   = scan_en && (scan_src_sel ? pwm_duty_evt : pwm_period_evt);
    m_done = 1'b0;
    set_ab = 1'b0;
    if (trig && m_own != 2) begin
      if (m_own == 1) begin set_ab = 1'b1; m_valid = 1'b0; end
      m_own = 2; m_cnt = 0;
    end else if (sw_start && m_own == 0) begin
      m_own = 1; m_cnt = 0; m_valid = 1'b0;
    end else if (m_own != 0 && tick) begin
      if (m_cnt == N_TICKS - 1) begin
        m_done = 1'b1;
        if (m_own == 1) m_valid = 1'b1;
        m_own = 0;
      end else m_cnt++;
    end
    if (set_ab) m_abort = 1'b1;
    else if (abort_clr) m_abort = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_sw();
    sw_start = 1'b1; cyc(); sw_start = 1'b0;
  endtask

  task automatic pulse_evt(bit duty);
    if (duty) pwm_duty_evt = 1'b1; else pwm_period_evt = 1'b1;
    cyc();
    pwm_duty_evt = 1'b0; pwm_period_evt = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sw_start = 0; pwm_period_evt = 0; pwm_duty_evt = 0;
    scan_en = 0; scan_src_sel = 0; abort_clr = 0; clk_div_sel = 3'd0;
    m_pc = 0; m_own = 0; m_cnt = 0; m_done = 0; m_abort = 0; m_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    cur_req = "R11";
    compare_all();

    // R7: every divide code, counted from reset release
    cur_req = "R7";
    for (int s = 0; s < 7; s++) begin
      clk_div_sel = 3'(s);
      run(140);
    end

    // R9 / R4: software conversion at divide-by-1
    clk_div_sel = 3'd0;
    cur_req = "R9";
    pulse_sw();
    check("R4", "valid low after sw start", sw_result_valid, 1'b0);
    check("R9", "busy_sw after start", busy_sw, 1'b1);
    run(2);
    check("R9", "no early done", conv_done, 1'b0);
    cyc();
    check("R9", "done after CONV_TICKS ticks", conv_done, 1'b1);
    check("R4", "valid after completion", sw_result_valid, 1'b1);
    cyc();
    check("R9", "done lasts one cycle", conv_done, 1'b0);

    // R2 / R3 / R4: scan preempts software conversion
    cur_req = "R2";
    scan_en = 1'b1; scan_src_sel = 1'b0;
    pulse_sw(); cyc();
    pulse_evt(1'b0);
    check("R2", "busy_scan after preempt", busy_scan, 1'b1);
    check("R3", "aborted set", sw_aborted, 1'b1);
    check("R4", "valid cleared by abort", sw_result_valid, 1'b0);
    cur_req = "R3";
    run(10);
    check("R3", "aborted sticky", sw_aborted, 1'b1);
    abort_clr = 1'b1; cyc(); abort_clr = 1'b0;
    check("R3", "aborted cleared", sw_aborted, 1'b0);

    // R1: simultaneous requests while idle
    cur_req = "R1";
    run(4);
    sw_start = 1'b1; pwm_period_evt = 1'b1; cyc();
    sw_start = 1'b0; pwm_period_evt = 1'b0;
    check("R1", "scan wins", busy_scan, 1'b1);
    check("R1", "sw dropped", busy_sw, 1'b0);
    run(8);
    check("R1", "sw start not queued", busy_sw, 1'b0);

    // R5: scan disabled
    cur_req = "R5";
    scan_en = 1'b0;
    pulse_evt(1'b0); pulse_evt(1'b1);
    check("R5", "no scan when disabled", busy_scan, 1'b0);

    // R6: source select
    cur_req = "R6";
    scan_en = 1'b1; scan_src_sel = 1'b1;
    pulse_evt(1'b0);
    check("R6", "period ignored with duty source", busy_scan, 1'b0);
    pulse_evt(1'b1);
    check("R6", "duty starts scan", busy_scan, 1'b1);

    // R10: requests while busy
    cur_req = "R10";
    pulse_sw();
    check("R10", "sw ignored during scan", busy_sw, 1'b0);
    run(6);

    // R8: stopped clock freezes a running conversion
    cur_req = "R8";
    pulse_sw();
    clk_div_sel = 3'd7;
    run(30);
    check("R8", "conversion frozen", busy_sw, 1'b1);
    clk_div_sel = 3'd0;
    run(5);

    // mixed random stimulus
    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      sw_start       = ($urandom % 6) == 0;
      pwm_period_evt = ($urandom % 7) == 0;
      pwm_duty_evt   = ($urandom % 7) == 0;
      abort_clr      = ($urandom % 12) == 0;
      if ($urandom % 50 == 0) scan_en = ~scan_en;
      if ($urandom % 40 == 0) scan_src_sel = ~scan_src_sel;
      if ($urandom % 60 == 0) clk_div_sel = 3'($urandom % 8);
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule